// File: doc/BRIEF.md
# Dual-Clock Mailbox Register with Bus Sizing

This block is a single-entry mailbox that carries one 36-bit word from a port A clock domain into a port B clock domain. It runs beside the main data queue and does not pass through it. Port A deposits a word with a qualified write on its clock. Port B collects the word with a qualified read on its own clock. An active-low flag in the port B domain goes low while the mailbox holds mail that has not been read.

The port B bus can be configured as 36, 18 or 9 bits wide. That setting masks the bits kept on capture and the bits presented on read. Bits above the configured width are driven to zero. The word stays in the mailbox after a read, so it can be read again.

The write event crosses into the B domain as a toggle through a two-stage synchronizer, and this sets the flag. The read acknowledgement returns to the A domain the same way. Until that acknowledgement arrives, port A refuses new mail.

Top module: `mbx_mailbox`

## Requirements
- R1: When `rst_n` is low, `mail_full_n` is forced high and `b_dout` is cleared to zero.
- R2: A port A mailbox write happens on a rising `clk_a` edge where `a_sel_n`=0, `a_dir_wr`=1, `a_ena`=1 and `a_mail_sel`=1. If it is accepted, `mail_full_n` goes low within eight `clk_b` cycles.
- R3: A port B mailbox read happens on a rising `clk_b` edge where `b_sel_n`=0, `b_dir_rd`=1, `b_ena`=1 and `b_mail_sel`=1. If `mail_full_n` was low, it is high after that edge.
- R4: With `b_width` = 2'b00 (long word), a read presents all 36 bits of the stored word on `b_dout` after the read edge. The code 2'b11 behaves the same way.
- R5: With `b_width` = 2'b01 (word), only `a_din[17:0]` is kept, and `b_dout[35:18]` reads as zero.
- R6: With `b_width` = 2'b10 (byte), only `a_din[8:0]` is kept, and `b_dout[35:9]` reads as zero.
- R7: The stored word stays in the mailbox after a read. A further read returns the same word and leaves `mail_full_n` high.
- R8: A port A cycle that fails any write qualifier, including `a_mail_sel`=0, leaves the flag and the stored word unchanged.
- R9: A port A mailbox write is ignored while earlier mail has not been read, or while its read acknowledgement has not yet returned to the A domain.
- R10: A port B cycle that fails any read qualifier leaves `mail_full_n` and `b_dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel_n | input | 1 | Port A select, active low |
| a_dir_wr | input | 1 | Port A direction, 1 = write |
| a_ena | input | 1 | Port A enable |
| a_mail_sel | input | 1 | Port A target, 1 = mailbox |
| a_din | input | 36 | Port A write data |
| b_sel_n | input | 1 | Port B select, active low |
| b_dir_rd | input | 1 | Port B direction, 1 = read |
| b_ena | input | 1 | Port B enable |
| b_mail_sel | input | 1 | Port B target, 1 = mailbox |
| b_width | input | 2 | Port B bus size: 00 long, 01 word, 10 byte, 11 long |
| b_dout | output | 36 | Mailbox read data, registered |
| mail_full_n | output | 1 | Unread mail present, active low |

## Verification
The assertions assume `b_width` is a quasi-static setting: it does not change while mail is pending. The bench changes it only after a read, once the acknowledgement has had time to return. The assertions also assume every qualifier input is stable around its clock edge. The bench drives port A only on falling `clk_a` edges and port B only on falling `clk_b` edges, using two unrelated clock periods. Random traffic waits out the synchronizer round trip before each new write, except in the directed cases that deliberately write into a full mailbox.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_WORD = 2'b01,
        SZ_BYTE = 2'b10,
        SZ_RSVD = 2'b11
    } bus_size_e;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_size_mask.sv
module mbx_size_mask
    import mbx_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int WORD_W = 18,
    parameter int BYTE_W = 9
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] dout
);
    localparam logic [DATA_W-1:0] WORD_MASK = {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};
    localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

    always_comb begin
        unique case (bus_size_e'(size))
            SZ_WORD: dout = din & WORD_MASK;
            SZ_BYTE: dout = din & BYTE_MASK;
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/mbx_wr_side.sv
module mbx_wr_side #(
    parameter int DATA_W      = 36,
    parameter int WORD_W      = 18,
    parameter int BYTE_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              rst_n,
    input  logic              a_sel_n,
    input  logic              a_dir_wr,
    input  logic              a_ena,
    input  logic              a_mail_sel,
    input  logic [DATA_W-1:0] a_din,
    input  logic [1:0]        size,
    input  logic              ack_tog,
    output logic              wr_tog,
    output logic [DATA_W-1:0] mail_data
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              wr_tog;
        logic              ack_seen;
        logic              busy;
    } wr_state_t;

    wr_state_t         st_d, st_q;
    logic              ack_s;
    logic              wr_fire;
    logic [DATA_W-1:0] masked;

    mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk  (clk_a),
        .rst_n(rst_n),
        .din  (ack_tog),
        .dout (ack_s)
    );

    mbx_size_mask #(.DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_mask (
        .din (a_din),
        .size(size),
        .dout(masked)
    );

    always_comb begin
        st_d    = st_q;
        wr_fire = !a_sel_n && a_dir_wr && a_ena && a_mail_sel && !st_q.busy;
        if (ack_s != st_q.ack_seen) begin
            st_d.ack_seen = ack_s;
            st_d.busy     = 1'b0;
        end
        if (wr_fire) begin
            st_d.data   = masked;
            st_d.wr_tog = ~st_q.wr_tog;
            st_d.busy   = 1'b1;
        end
    end

    always_ff @(posedge clk_a or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_tog    = st_q.wr_tog;
    assign mail_data = st_q.data;
endmodule

// File: rtl/mbx_rd_side.sv
module mbx_rd_side #(
    parameter int DATA_W      = 36,
    parameter int WORD_W      = 18,
    parameter int BYTE_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              b_sel_n,
    input  logic              b_dir_rd,
    input  logic              b_ena,
    input  logic              b_mail_sel,
    input  logic [1:0]        b_width,
    input  logic              wr_tog,
    input  logic [DATA_W-1:0] mail_data,
    output logic              ack_tog,
    output logic              mail_full_n,
    output logic [DATA_W-1:0] b_dout
);
    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic              wr_seen;
        logic              full;
        logic              ack_tog;
    } rd_state_t;

    rd_state_t         st_d, st_q;
    logic              wr_s;
    logic              rd_fire;
    logic [DATA_W-1:0] masked;

    mbx_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk  (clk_b),
        .rst_n(rst_n),
        .din  (wr_tog),
        .dout (wr_s)
    );

    mbx_size_mask #(.DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_mask (
        .din (mail_data),
        .size(b_width),
        .dout(masked)
    );

    always_comb begin
        st_d    = st_q;
        rd_fire = !b_sel_n && b_dir_rd && b_ena && b_mail_sel;
        if (rd_fire) begin
            st_d.dout = masked;
            if (st_q.full) begin
                st_d.full    = 1'b0;
                st_d.ack_tog = ~st_q.ack_tog;
            end
        end
        if (wr_s != st_q.wr_seen) begin
            st_d.wr_seen = wr_s;
            st_d.full    = 1'b1;
        end
    end

    always_ff @(posedge clk_b or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_tog     = st_q.ack_tog;
    assign mail_full_n = ~st_q.full;
    assign b_dout      = st_q.dout;
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox #(
    parameter int DATA_W      = 36,
    parameter int WORD_W      = 18,
    parameter int BYTE_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              a_sel_n,
    input  logic              a_dir_wr,
    input  logic              a_ena,
    input  logic              a_mail_sel,
    input  logic [DATA_W-1:0] a_din,
    input  logic              b_sel_n,
    input  logic              b_dir_rd,
    input  logic              b_ena,
    input  logic              b_mail_sel,
    input  logic [1:0]        b_width,
    output logic [DATA_W-1:0] b_dout,
    output logic              mail_full_n
);
    logic              wr_tog;
    logic              ack_tog;
    logic [DATA_W-1:0] mail_data;

    mbx_wr_side #(
        .DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_wr (
        .clk_a     (clk_a),
        .rst_n     (rst_n),
        .a_sel_n   (a_sel_n),
        .a_dir_wr  (a_dir_wr),
        .a_ena     (a_ena),
        .a_mail_sel(a_mail_sel),
        .a_din     (a_din),
        .size      (b_width),
        .ack_tog   (ack_tog),
        .wr_tog    (wr_tog),
        .mail_data (mail_data)
    );

    mbx_rd_side #(
        .DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_rd (
        .clk_b      (clk_b),
        .rst_n      (rst_n),
        .b_sel_n    (b_sel_n),
        .b_dir_rd   (b_dir_rd),
        .b_ena      (b_ena),
        .b_mail_sel (b_mail_sel),
        .b_width    (b_width),
        .wr_tog     (wr_tog),
        .mail_data  (mail_data),
        .ack_tog    (ack_tog),
        .mail_full_n(mail_full_n),
        .b_dout     (b_dout)
    );
endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk #(
    parameter int DATA_W = 36,
    parameter int WORD_W = 18,
    parameter int BYTE_W = 9
) (
    input logic              clk_b,
    input logic              rst_n,
    input logic              b_sel_n,
    input logic              b_dir_rd,
    input logic              b_ena,
    input logic              b_mail_sel,
    input logic [1:0]        b_width,
    input logic [DATA_W-1:0] b_dout,
    input logic              mail_full_n
);
    logic rd_ok;
    assign rd_ok = !b_sel_n && b_dir_rd && b_ena && b_mail_sel;

    // R3
    read_clears_flag_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        (rd_ok && !mail_full_n) |=> mail_full_n);

    // R5
    word_upper_zero_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        (rd_ok && b_width == 2'b01) |=> (b_dout[DATA_W-1:WORD_W] == '0));

    // R6
    byte_upper_zero_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        (rd_ok && b_width == 2'b10) |=> (b_dout[DATA_W-1:BYTE_W] == '0));

    // R10
    idle_keeps_dout_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !rd_ok |=> $stable(b_dout));

    // R10
    idle_keeps_flag_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !rd_ok |=> !$rose(mail_full_n));
endmodule

bind mbx_mailbox mbx_mailbox_chk #(
    .DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)
) u_chk (
    .clk_b      (clk_b),
    .rst_n      (rst_n),
    .b_sel_n    (b_sel_n),
    .b_dir_rd   (b_dir_rd),
    .b_ena      (b_ena),
    .b_mail_sel (b_mail_sel),
    .b_width    (b_width),
    .b_dout     (b_dout),
    .mail_full_n(mail_full_n)
);

// File: tb/mbx_mailbox_test.sv
`timescale 1ns/1ps
module mbx_mailbox_test;
    logic        clk_a = 0, clk_b = 0, rst_n = 0;
    logic        a_sel_n = 1, a_dir_wr = 0, a_ena = 0, a_mail_sel = 0;
    logic [35:0] a_din = '0;
    logic        b_sel_n = 1, b_dir_rd = 0, b_ena = 0, b_mail_sel = 0;
    logic [1:0]  b_width = 2'b00;
    logic [35:0] b_dout;
    logic        mail_full_n;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk_b = ~clk_b;
    always #3.7 clk_a = ~clk_a;

    mbx_mailbox uut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_sel_n(a_sel_n), .a_dir_wr(a_dir_wr), .a_ena(a_ena), .a_mail_sel(a_mail_sel),
        .a_din(a_din),
        .b_sel_n(b_sel_n), .b_dir_rd(b_dir_rd), .b_ena(b_ena), .b_mail_sel(b_mail_sel),
        .b_width(b_width), .b_dout(b_dout), .mail_full_n(mail_full_n)
    );

    function automatic logic [35:0] exp_mask(input logic [35:0] d, input logic [1:0] sz);
        if (sz == 2'b01)      return {18'd0, d[17:0]};
        else if (sz == 2'b10) return {27'd0, d[8:0]};
        else                  return d;
    endfunction

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic a_cycle(input logic [35:0] d, input bit sel_n, input bit wr, input bit en, input bit mbx);
        @(negedge clk_a);
        a_din = d; a_sel_n = sel_n; a_dir_wr = wr; a_ena = en; a_mail_sel = mbx;
        @(negedge clk_a);
        a_sel_n = 1; a_dir_wr = 0; a_ena = 0; a_mail_sel = 0;
    endtask

    task automatic b_cycle(input bit sel_n, input bit rd, input bit en, input bit mbx);
        @(negedge clk_b);
        b_sel_n = sel_n; b_dir_rd = rd; b_ena = en; b_mail_sel = mbx;
        @(negedge clk_b);
        b_sel_n = 1; b_dir_rd = 0; b_ena = 0; b_mail_sel = 0;
    endtask

    task automatic settle_b(); repeat (8) @(negedge clk_b); endtask
    task automatic settle_a(); repeat (10) @(negedge clk_a); endtask

    initial begin
        repeat (200000) @(posedge clk_b);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 36'd0, 36'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [35:0] w, x, prev;
        void'($urandom(32'h5EED_1234));
        rst_n = 0;
        #1;
        // R1: reset state
        check(mail_full_n == 1'b1, "R1 flag", {35'd0, mail_full_n}, 36'd1);
        check(b_dout == 36'd0, "R1 dout", b_dout, 36'd0);
        repeat (3) @(negedge clk_b);
        rst_n = 1;
        repeat (3) @(negedge clk_b);

        // R2, R3, R4: long word round trip
        w = 36'hA_5C3F_1E27;
        b_width = 2'b00;
        a_cycle(w, 0, 1, 1, 1);
        settle_b();
        check(mail_full_n == 1'b0, "R2 flag low", {35'd0, mail_full_n}, 36'd0);
        b_cycle(0, 1, 1, 1);
        check(b_dout == w, "R4 long data", b_dout, w);
        check(mail_full_n == 1'b1, "R3 flag high", {35'd0, mail_full_n}, 36'd1);

        // R7: re-read retains the word
        b_cycle(0, 1, 1, 1);
        check(b_dout == w, "R7 reread", b_dout, w);
        check(mail_full_n == 1'b1, "R7 flag", {35'd0, mail_full_n}, 36'd1);
        settle_a();

        // R8: unqualified port A cycles
        a_cycle(36'hF_FFFF_FFFF, 0, 1, 1, 0);
        a_cycle(36'h1_1111_1111, 1, 1, 1, 1);
        a_cycle(36'h2_2222_2222, 0, 0, 1, 1);
        a_cycle(36'h3_3333_3333, 0, 1, 0, 1);
        settle_b();
        check(mail_full_n == 1'b1, "R8 flag", {35'd0, mail_full_n}, 36'd1);
        b_cycle(0, 1, 1, 1);
        check(b_dout == w, "R8 data", b_dout, w);

        // R9: write into full mailbox is ignored
        w = 36'h0_DEAD_BEEF; x = 36'h9_0F0F_0F0F;
        a_cycle(w, 0, 1, 1, 1);
        settle_b();
        a_cycle(x, 0, 1, 1, 1);
        settle_b();
        b_cycle(0, 1, 1, 1);
        check(b_dout == w, "R9 first kept", b_dout, w);
        settle_a();

        // R10: unqualified reads keep flag and output
        prev = b_dout;
        x = 36'h7_7654_3210;
        a_cycle(x, 0, 1, 1, 1);
        settle_b();
        b_cycle(0, 1, 1, 0);
        check(mail_full_n == 1'b0, "R10 flag mbx=0", {35'd0, mail_full_n}, 36'd0);
        check(b_dout == prev, "R10 dout mbx=0", b_dout, prev);
        b_cycle(0, 1, 0, 1);
        b_cycle(1, 1, 1, 1);
        b_cycle(0, 0, 1, 1);
        check(mail_full_n == 1'b0, "R10 flag others", {35'd0, mail_full_n}, 36'd0);
        check(b_dout == prev, "R10 dout others", b_dout, prev);
        b_cycle(0, 1, 1, 1);
        check(b_dout == x, "R10 then read", b_dout, x);
        settle_a();

        // R5: word width
        b_width = 2'b01;
        w = 36'hF_FFFF_FFFF;
        a_cycle(w, 0, 1, 1, 1);
        settle_b();
        b_cycle(0, 1, 1, 1);
        check(b_dout == 36'h0_0003_FFFF, "R5 word", b_dout, 36'h0_0003_FFFF);
        settle_a();

        // R6: byte width
        b_width = 2'b10;
        a_cycle(w, 0, 1, 1, 1);
        settle_b();
        b_cycle(0, 1, 1, 1);
        check(b_dout == 36'h0_0000_01FF, "R6 byte", b_dout, 36'h0_0000_01FF);
        settle_a();

        // R4: reserved code acts as long
        b_width = 2'b11;
        a_cycle(w, 0, 1, 1, 1);
        settle_b();
        b_cycle(0, 1, 1, 1);
        check(b_dout == w, "R4 code 11", b_dout, w);
        settle_a();

        // Random traffic over R2..R7, R9
        for (int i = 0; i < 40; i++) begin
            logic [1:0] sz;
            sz = 2'($urandom_range(0, 3));
            b_width = sz;
            w = {4'($urandom), 32'($urandom)};
            a_cycle(w, 0, 1, 1, 1);
            settle_b();
            check(mail_full_n == 1'b0, "R2 random flag", {35'd0, mail_full_n}, 36'd0);
            if ($urandom_range(0, 3) == 0) begin
                a_cycle(~w, 0, 1, 1, 1);
                settle_b();
            end
            b_cycle(0, 1, 1, 1);
            check(b_dout == exp_mask(w, sz), "R9 random data", b_dout, exp_mask(w, sz));
            check(mail_full_n == 1'b1, "R3 random flag", {35'd0, mail_full_n}, 36'd1);
            settle_a();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule